// File: doc/BRIEF.md
# Floating-Point Min/Max Selector with Output Saturation

This unit takes two single-precision floating-point operands and an 8-bit operation code, picks the smaller or larger of the two, and then applies a 2-bit output modifier that can saturate the chosen value. Each comparison has two forms. The tolerant form returns the other operand when one operand is NaN. The strict form returns the NaN operand. Both forms also come in a magnitude version that drops the sign bits of the operands before comparing.

The unit sits in a shader datapath stage. Its issue logic pulses `in_valid` together with the operands, the code and the modifier. The registered result appears with `out_valid` on the next clock edge. There is no handshake and no stall. A new operation may be issued on every cycle. Subnormal values are compared and returned bit-exact, with no flushing. No exception flags are produced.

The design has no sequencing states. It is a single registered stage: the selector and the saturation logic are combinational, and they feed one output register.

Top module: `fmm_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released with no issue, `out_valid` is 0 and `out_result` is 0x00000000.
- R2: An operation issued with `in_valid` high at one rising edge drives `out_valid` high, with its result, after exactly that edge. A cycle without `in_valid` gives `out_valid` low on the following edge.
- R3: Supported operation codes:
  - 0x28: min, tolerant
  - 0x29: min, strict
  - 0x2A: magnitude min, tolerant
  - 0x2B: magnitude min, strict
  - 0x2C: max, tolerant
  - 0x2D: max, strict
  - 0x2E: magnitude max, tolerant
  - 0x2F: magnitude max, strict

  When neither operand is NaN, min returns the numerically smaller operand and max returns the larger one.
- R4: In the tolerant forms (0x28, 0x2A, 0x2C, 0x2E), if exactly one operand is NaN, the other operand is returned.
- R5: In the strict forms (0x29, 0x2B, 0x2D, 0x2F), if exactly one operand is NaN, that NaN operand is returned unchanged, except that magnitude forms clear its sign bit.
- R6: The magnitude forms (0x2A, 0x2B, 0x2E, 0x2F) clear bit 31 of both operands before comparing, and return the selected magnitude with bit 31 clear.
- R7: If both operands are NaN, the result is operand A (sign cleared in magnitude forms) with bit 22, the quiet bit, forced to 1.
- R8: Negative zero orders below positive zero: min(+0,-0) returns 0x80000000 and max(-0,+0) returns 0x00000000.
- R9: Modifier 1 returns +0.0 for any value with bit 31 set or any NaN. All other values pass through.
- R10: Modifier 2 limits the value to [-1.0, 1.0]. A value whose magnitude exceeds 1.0 becomes 1.0 with its own sign, and a NaN becomes -1.0 (0xBF800000).
- R11: Modifier 3 limits the value to [0.0, 1.0]. Any NaN or any value with bit 31 set becomes +0.0, and a value above 1.0 becomes 1.0 (0x3F800000). Modifier 0 leaves the value unchanged.
- R12: For any operation code outside 0x28 to 0x2F, the result is operand A, passed through the selected modifier.
- R13: Subnormal operands are compared by value and returned bit-exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe for the current operands |
| in_op | input | 8 | Operation code |
| in_a | input | 32 | Operand A, single precision |
| in_b | input | 32 | Operand B, single precision |
| in_omod | input | 2 | Output modifier: 0 pass, 1 non-negative, 2 symmetric unit, 3 unit interval |
| out_valid | output | 1 | Result qualifier, one cycle after issue |
| out_result | output | 32 | Registered result |

## Verification
Every result is due exactly one rising edge after its issue edge, because the only registers on the path are the output stage. The bench drives the inputs on a falling edge and waits for one rising edge. It then samples `out_valid` and `out_result` at the next falling edge, and drops `in_valid` before that edge. Idle cycles are checked the same way, to confirm that `out_valid` falls one edge after the strobe stops.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

    typedef enum logic [1:0] {
        OM_PASS = 2'd0,
        OM_POS  = 2'd1,
        OM_SYM  = 2'd2,
        OM_UNIT = 2'd3
    } omod_e;

    // upper five opcode bits shared by the eight min/max codes
    localparam logic [4:0] OP_GROUP = 5'b00101;
    // low opcode bit meanings inside the group
    localparam int OPB_STRICT = 0;
    localparam int OPB_MAG    = 1;
    localparam int OPB_MAX    = 2;

endpackage

// File: rtl/fmm_select.sv
module fmm_select
    import fmm_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [7:0]               op,
    input  logic [EXP_W+MAN_W:0]     a,
    input  logic [EXP_W+MAN_W:0]     b,
    output logic [EXP_W+MAN_W:0]     y
);
    localparam int W    = 1 + EXP_W + MAN_W;
    localparam int QBIT = MAN_W - 1;

    logic         in_group;
    logic [W-1:0] ua, ub, ka, kb, q_mask;
    logic         a_nan, b_nan, a_less, take_a;

    always_comb begin
        in_group = (op[7:3] == OP_GROUP);
        ua = a;
        ub = b;
        if (in_group && op[OPB_MAG]) begin
            ua[W-1] = 1'b0;
            ub[W-1] = 1'b0;
        end
        a_nan = (&ua[W-2:MAN_W]) && (|ua[MAN_W-1:0]);
        b_nan = (&ub[W-2:MAN_W]) && (|ub[MAN_W-1:0]);
        // monotone unsigned key: negatives inverted, positives get top bit set
        ka = ua[W-1] ? ~ua : (ua | {1'b1, {(W-1){1'b0}}});
        kb = ub[W-1] ? ~ub : (ub | {1'b1, {(W-1){1'b0}}});
        a_less = (ka < kb);
        take_a = op[OPB_MAX] ? !a_less : a_less;
        q_mask = '0;
        q_mask[QBIT] = 1'b1;

        if (!in_group)
            y = a;
        else if (a_nan && b_nan)
            y = ua | q_mask;
        else if (a_nan)
            y = op[OPB_STRICT] ? ua : ub;
        else if (b_nan)
            y = op[OPB_STRICT] ? ub : ua;
        else
            y = take_a ? ua : ub;
    end

endmodule

// File: rtl/fmm_clamp.sv
module fmm_clamp
    import fmm_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [1:0]               mode,
    input  logic [EXP_W+MAN_W:0]     x,
    output logic [EXP_W+MAN_W:0]     y
);
    localparam int W = 1 + EXP_W + MAN_W;
    localparam logic [W-2:0] ONE_MAG = {1'b0, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

    logic  x_nan, x_neg, over_one;
    omod_e m;

    always_comb begin
        m        = omod_e'(mode);
        x_nan    = (&x[W-2:MAN_W]) && (|x[MAN_W-1:0]);
        x_neg    = x[W-1];
        over_one = (x[W-2:0] > ONE_MAG);
        unique case (m)
            OM_PASS: y = x;
            OM_POS:  y = (x_nan || x_neg) ? '0 : x;
            OM_SYM: begin
                if (x_nan)
                    y = {1'b1, ONE_MAG};
                else if (over_one)
                    y = {x_neg, ONE_MAG};
                else
                    y = x;
            end
            OM_UNIT: begin
                if (x_nan || x_neg)
                    y = '0;
                else if (over_one)
                    y = {1'b0, ONE_MAG};
                else
                    y = x;
            end
        endcase
    end

endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
    import fmm_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [7:0]             in_op,
    input  logic [EXP_W+MAN_W:0]   in_a,
    input  logic [EXP_W+MAN_W:0]   in_b,
    input  logic [1:0]             in_omod,
    output logic                   out_valid,
    output logic [EXP_W+MAN_W:0]   out_result
);
    localparam int W = 1 + EXP_W + MAN_W;
    localparam logic [W-2:0] ONE_MAG = {1'b0, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

    logic [W-1:0] sel_val, sat_val;

    fmm_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sel (
        .op (in_op),
        .a  (in_a),
        .b  (in_b),
        .y  (sel_val)
    );

    fmm_clamp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sat (
        .mode (in_omod),
        .x    (sel_val),
        .y    (sat_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_result <= sat_val;
        end
    end

    // R2: issue strobe appears one edge later
    a_r2_issue_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9/R10/R11: any non-zero modifier never yields a NaN
    a_r9_no_nan_out: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_omod != 2'd0) |=>
        !((&out_result[W-2:MAN_W]) && (|out_result[MAN_W-1:0])));

    // R11: unit-interval modifier gives non-negative magnitude at most one
    a_r11_unit_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_omod == 2'd3) |=>
        (!out_result[W-1] && out_result[W-2:0] <= ONE_MAG));

    // R10: symmetric modifier bounds the magnitude
    a_r10_sym_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_omod == 2'd2) |=> (out_result[W-2:0] <= ONE_MAG));

    // R6: magnitude forms never return a set sign without a modifier
    a_r6_mag_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[7:3] == OP_GROUP && in_op[OPB_MAG] && in_omod == 2'd0)
        |=> !out_result[W-1]);

    // R3: plain min/max result equals one of the operands
    a_r3_pick_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[7:3] == OP_GROUP && !in_op[OPB_MAG] && in_omod == 2'd0
         && !((&in_a[W-2:MAN_W]) && (|in_a[MAN_W-1:0]))
         && !((&in_b[W-2:MAN_W]) && (|in_b[MAN_W-1:0])))
        |=> (out_result == $past(in_a) || out_result == $past(in_b)));

endmodule

// File: tb/fmm_unit_test.sv
`timescale 1ns/1ps
module fmm_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_op = '0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic [1:0]  in_omod = '0;
    logic        out_valid;
    logic [31:0] out_result;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    fmm_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_omod(in_omod),
        .out_valid(out_valid), .out_result(out_result)
    );

    localparam logic [31:0] P1 = 32'h3F800000, N1 = 32'hBF800000;
    localparam logic [31:0] P2 = 32'h40000000, N2 = 32'hC0000000;
    localparam logic [31:0] P3 = 32'h40400000, N3 = 32'hC0400000;
    localparam logic [31:0] P4 = 32'h40800000, N4 = 32'hC0800000;
    localparam logic [31:0] P5 = 32'h40A00000, N7 = 32'hC0E00000;
    localparam logic [31:0] PH = 32'h3F000000, NH = 32'hBF000000;
    localparam logic [31:0] PQ = 32'h3E800000;
    localparam logic [31:0] QNAN = 32'h7FC00000, NQNAN = 32'hFFC00000;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // issue one operation and check the result one edge later
    task automatic issue(input string req, input logic [7:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [1:0] om, input logic [31:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_omod = om;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check(req, out_result, exp);
    endtask

    task automatic t_reset;
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 result", out_result, 32'd0);
    endtask

    task automatic t_latency;
        issue("R2 issue", 8'h28, P1, P2, 2'd0, P1);
        @(negedge clk);
        check("R2 idle drop", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_order;
        issue("R3 min", 8'h28, P2, P1, 2'd0, P1);
        issue("R3 max mixed", 8'h2C, N3, P2, 2'd0, P2);
        issue("R3 max neg", 8'h2C, N1, N2, 2'd0, N1);
        issue("R3 min strict", 8'h29, N4, P3, 2'd0, N4);
    endtask

    task automatic t_tolerant;
        issue("R4 min nan a", 8'h28, QNAN, P5, 2'd0, P5);
        issue("R4 max nan b", 8'h2C, P2, NQNAN, 2'd0, P2);
    endtask

    task automatic t_strict;
        issue("R5 min_nan", 8'h29, P1, 32'h7FC00001, 2'd0, 32'h7FC00001);
        issue("R5 max_nan", 8'h2D, NQNAN, P3, 2'd0, NQNAN);
    endtask

    task automatic t_mag;
        issue("R6 absmin", 8'h2A, N1, P2, 2'd0, P1);
        issue("R6 absmax", 8'h2E, N4, P3, 2'd0, P4);
        issue("R6 absmax_nan", 8'h2F, NQNAN, P1, 2'd0, QNAN);
    endtask

    task automatic t_both_nan;
        issue("R7 both nan", 8'h28, 32'h7F800001, QNAN, 2'd0, 32'h7FC00001);
    endtask

    task automatic t_zero;
        issue("R8 min zeros", 8'h28, 32'h0, 32'h80000000, 2'd0, 32'h80000000);
        issue("R8 max zeros", 8'h2C, 32'h80000000, 32'h0, 2'd0, 32'h0);
    endtask

    task automatic t_om1;
        issue("R9 negative", 8'h2C, N2, N3, 2'd1, 32'h0);
        issue("R9 nan", 8'h29, QNAN, P1, 2'd1, 32'h0);
        issue("R9 pass", 8'h2C, P5, P1, 2'd1, P5);
    endtask

    task automatic t_om2;
        issue("R10 high", 8'h2C, P3, P1, 2'd2, P1);
        issue("R10 low", 8'h28, N7, P1, 2'd2, N1);
        issue("R10 nan", 8'h2D, QNAN, P1, 2'd2, N1);
        issue("R10 inside", 8'h28, PH, P1, 2'd2, PH);
    endtask

    task automatic t_om3;
        issue("R11 negative", 8'h28, NH, P1, 2'd3, 32'h0);
        issue("R11 high", 8'h2C, P2, P1, 2'd3, P1);
        issue("R11 nan", 8'h2D, QNAN, P1, 2'd3, 32'h0);
        issue("R11 inside", 8'h28, PQ, P1, 2'd3, PQ);
    endtask

    task automatic t_unknown;
        issue("R12 unknown op", 8'h10, P3, 32'h0, 2'd0, P3);
        issue("R12 unknown clamp", 8'h30, P3, 32'h0, 2'd3, P1);
    endtask

    task automatic t_subnormal;
        issue("R13 min sub", 8'h28, 32'h00000002, 32'h00000001, 2'd0, 32'h00000001);
        issue("R13 max sub", 8'h2C, 32'h80000003, 32'h00000002, 2'd0, 32'h00000002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_latency();
        t_order();
        t_tolerant();
        t_strict();
        t_mag();
        t_both_nan();
        t_zero();
        t_om1();
        t_om2();
        t_om3();
        t_unknown();
        t_subnormal();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

endmodule